// File: doc/BRIEF.md
# Core-local exclusive reservation monitor

This block sits next to a processor core's load/store pipeline. It keeps a single reservation that records the address and access size of the last load-exclusive. It then decides whether a later store-exclusive may write memory. A passing store raises a registered write enable and forwards its address, size and data. Every store-exclusive produces a one-cycle result pulse with status 0 for success or 1 for failure.

For memory marked shareable, the local verdict is only half of the answer. The block asks a system-level monitor through a combinational query line. It asks only when its own reservation already matches, and it combines that answer with the per-core verdict on `sys_pass`.

The reservation is a two-state machine:
- RSV_IDLE means no reservation is held.
- RSV_HELD means a reservation is held.

It moves along these transitions:
- T_MARK: RSV_IDLE to RSV_HELD when a load-exclusive arrives.
- T_REMARK: RSV_HELD to RSV_HELD when a load-exclusive arrives. The address and size are replaced.
- T_CONSUME: RSV_HELD to RSV_IDLE on any store-exclusive, whether it passes or fails.
- T_DROP: RSV_HELD to RSV_IDLE on a clear request.
- T_STAY: RSV_IDLE to RSV_IDLE on a store or a clear.

In one cycle the requests rank as follows: clear above store, and store above load. A lower-ranked request in the same cycle as a higher one takes no effect on the reservation.

Top module: `excl_reservation_unit`

## Requirements
- R1: After reset no reservation is held. `wr_en`, `st_done`, `st_status` and `sys_query` are 0, and a first store-exclusive fails.
- R2: A load-exclusive (`ld_req`) records its address and size. A second load-exclusive while a reservation is held completes normally and replaces the recorded address and size.
- R3: A store-exclusive whose address and size equal the reservation, on non-shareable memory, gives `wr_en`=1 and `st_status`=0 in the next cycle. In that cycle `wr_addr`, `wr_size` and `wr_data` equal the store's inputs.
- R4: A store-exclusive with no reservation held gives `st_status`=1 and `wr_en`=0.
- R5: Every store-exclusive clears the reservation whether it passes or not. A second store after a successful one fails until a new load-exclusive.
- R6: A store-exclusive whose address or size differs from the reservation fails and clears it. The size encoding is 0 byte, 1 halfword, 2 word, 3 doubleword.
- R7: On shareable memory (`shareable`=1), a locally matching store passes only if `sys_pass`=1. Otherwise it fails with no write.
- R8: `sys_query` is high, combinationally, only during a shareable store-exclusive whose local reservation matches and which is not overridden by a clear. It is never high when the local check fails.
- R9: `clr_req` clears the reservation. A store in the same cycle as a clear fails, and a load in the same cycle as a clear or a store is ignored.
- R10: `st_done` is high for exactly the one cycle after each store-exclusive request and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Load-exclusive request |
| ld_addr | input | AW | Load-exclusive address |
| ld_size | input | 2 | Load-exclusive size code |
| st_req | input | 1 | Store-exclusive request |
| st_addr | input | AW | Store-exclusive address |
| st_size | input | 2 | Store-exclusive size code |
| st_data | input | DW | Store-exclusive data |
| shareable | input | 1 | Store target is shareable memory |
| sys_pass | input | 1 | System monitor verdict for this core |
| clr_req | input | 1 | Clear-exclusive request |
| sys_query | output | 1 | Combinational query to the system monitor |
| wr_en | output | 1 | Registered memory write enable |
| wr_addr | output | AW | Registered write address |
| wr_size | output | 2 | Registered write size code |
| wr_data | output | DW | Registered write data |
| st_done | output | 1 | Store result valid |
| st_status | output | 1 | 0 success, 1 failure |

## Verification
The assertions watch several rules on every cycle:
- A write appears only alongside a success status.
- Any store or clear leaves the machine in RSV_IDLE.
- A load alone leaves it in RSV_HELD.
- A store with nothing held fails.
- The system query never rises without a held reservation.

Some behaviour only the bench scenarios can show:
- The address and size comparison against a recorded reservation, including the replacement on a repeated load.
- The priority outcomes when requests collide in one cycle.
- The echoed write address and data.

The bench's reference model covers these over directed cases and a seeded random mix.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } xsize_t;

    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_t;
endpackage

// File: rtl/excl_tag_fsm.sv
module excl_tag_fsm
    import excl_mon_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_req,
    input  logic [AW-1:0] ld_addr,
    input  xsize_t        ld_size,
    input  logic          st_req,
    input  logic          clr_req,
    output logic          held,
    output logic [AW-1:0] held_addr,
    output xsize_t        held_size
);
    rsv_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    xsize_t        size_q;
    logic          capture;

    // Next state: clear and store outrank load
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            RSV_IDLE: begin
                if (!clr_req && !st_req && ld_req) begin
                    state_d = RSV_HELD;          // T_MARK
                    capture = 1'b1;
                end
            end
            RSV_HELD: begin
                if (clr_req || st_req) begin
                    state_d = RSV_IDLE;          // T_DROP / T_CONSUME
                end else if (ld_req) begin
                    state_d = RSV_HELD;          // T_REMARK
                    capture = 1'b1;
                end
            end
            default: state_d = RSV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_IDLE;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
        end else begin
            state_q <= state_d;
            if (capture) begin
                addr_q <= ld_addr;
                size_q <= ld_size;
            end
        end
    end

    always_comb begin
        held      = (state_q == RSV_HELD);
        held_addr = addr_q;
        held_size = size_q;
    end
endmodule

// File: rtl/excl_match.sv
module excl_match
    import excl_mon_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MATCH_LSB = 0
) (
    input  logic          held,
    input  logic [AW-1:0] held_addr,
    input  xsize_t        held_size,
    input  logic [AW-1:0] st_addr,
    input  xsize_t        st_size,
    output logic          hit
);
    logic addr_eq;

    generate
        if (MATCH_LSB == 0) begin : g_full
            assign addr_eq = (held_addr == st_addr);
        end else begin : g_granule
            assign addr_eq = (held_addr[AW-1:MATCH_LSB] == st_addr[AW-1:MATCH_LSB]);
        end
    endgenerate

    assign hit = held && addr_eq && (held_size == st_size);
endmodule

// File: rtl/excl_verdict.sv
module excl_verdict (
    input  logic st_req,
    input  logic clr_req,
    input  logic local_hit,
    input  logic shareable,
    input  logic sys_pass,
    output logic sys_query,
    output logic pass
);
    logic local_ok;

    always_comb begin
        local_ok  = local_hit && !clr_req;
        // The system monitor is asked only once the local check is good
        sys_query = st_req && shareable && local_ok;
        pass      = st_req && local_ok && (!shareable || sys_pass);
    end
endmodule

// File: rtl/excl_result_reg.sv
module excl_result_reg #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_req,
    input  logic          pass,
    input  logic [AW-1:0] st_addr,
    input  logic [1:0]    st_size,
    input  logic [DW-1:0] st_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_size,
    output logic [DW-1:0] wr_data,
    output logic          st_done,
    output logic          st_status
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_size   <= '0;
            wr_data   <= '0;
            st_done   <= 1'b0;
            st_status <= 1'b0;
        end else begin
            wr_en     <= pass;
            st_done   <= st_req;
            st_status <= st_req && !pass;
            if (pass) begin
                wr_addr <= st_addr;
                wr_size <= st_size;
                wr_data <= st_data;
            end
        end
    end
endmodule

// File: rtl/excl_reservation_unit.sv
module excl_reservation_unit
    import excl_mon_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 64,
    parameter int MATCH_LSB = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_req,
    input  logic [AW-1:0] ld_addr,
    input  logic [1:0]    ld_size,
    input  logic          st_req,
    input  logic [AW-1:0] st_addr,
    input  logic [1:0]    st_size,
    input  logic [DW-1:0] st_data,
    input  logic          shareable,
    input  logic          sys_pass,
    input  logic          clr_req,
    output logic          sys_query,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_size,
    output logic [DW-1:0] wr_data,
    output logic          st_done,
    output logic          st_status
);
    logic          held;
    logic [AW-1:0] held_addr;
    xsize_t        held_size;
    logic          local_hit;
    logic          pass;

    excl_tag_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_req    (ld_req),
        .ld_addr   (ld_addr),
        .ld_size   (xsize_t'(ld_size)),
        .st_req    (st_req),
        .clr_req   (clr_req),
        .held      (held),
        .held_addr (held_addr),
        .held_size (held_size)
    );

    excl_match #(.AW(AW), .MATCH_LSB(MATCH_LSB)) u_match (
        .held      (held),
        .held_addr (held_addr),
        .held_size (held_size),
        .st_addr   (st_addr),
        .st_size   (xsize_t'(st_size)),
        .hit       (local_hit)
    );

    excl_verdict u_verdict (
        .st_req    (st_req),
        .clr_req   (clr_req),
        .local_hit (local_hit),
        .shareable (shareable),
        .sys_pass  (sys_pass),
        .sys_query (sys_query),
        .pass      (pass)
    );

    excl_result_reg #(.AW(AW), .DW(DW)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_req    (st_req),
        .pass      (pass),
        .st_addr   (st_addr),
        .st_size   (st_size),
        .st_data   (st_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_size   (wr_size),
        .wr_data   (wr_data),
        .st_done   (st_done),
        .st_status (st_status)
    );
endmodule

// File: rtl/excl_reservation_checker.sv
module excl_reservation_checker (
    input logic clk,
    input logic rst_n,
    input logic ld_req,
    input logic st_req,
    input logic clr_req,
    input logic shareable,
    input logic sys_query,
    input logic held,
    input logic wr_en,
    input logic st_done,
    input logic st_status
);
    AST_WRITE_ONLY_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_done && !st_status));                       // R3
    AST_EMPTY_STORE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !held) |=> (st_done && st_status && !wr_en));  // R4
    AST_STORE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |=> !held);                                        // R5
    AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !st_req && !clr_req) |=> held);                // R2
    AST_QUERY_NEEDS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        sys_query |-> (held && st_req && shareable && !clr_req)); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !held);                                       // R9
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |=> st_done);                                      // R10
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_req |=> !st_done);                                    // R10
endmodule

bind excl_reservation_unit excl_reservation_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_req    (ld_req),
    .st_req    (st_req),
    .clr_req   (clr_req),
    .shareable (shareable),
    .sys_query (sys_query),
    .held      (held),
    .wr_en     (wr_en),
    .st_done   (st_done),
    .st_status (st_status)
);

// File: tb/excl_reservation_unit_tb.sv
module excl_reservation_unit_tb;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_req, st_req, clr_req, shareable, sys_pass;
    logic [AW-1:0] ld_addr, st_addr;
    logic [1:0]    ld_size, st_size;
    logic [DW-1:0] st_data;
    logic          sys_query, wr_en, st_done, st_status;
    logic [AW-1:0] wr_addr;
    logic [1:0]    wr_size;
    logic [DW-1:0] wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Reference reservation
    bit            m_held = 0;
    logic [AW-1:0] m_addr = '0;
    logic [1:0]    m_size = '0;

    always #2.5 clk = ~clk;

    excl_reservation_unit #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size),
        .st_req(st_req), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .shareable(shareable), .sys_pass(sys_pass), .clr_req(clr_req),
        .sys_query(sys_query), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data),
        .st_done(st_done), .st_status(st_status)
    );

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [AW-1:0] a, input logic [1:0] s);
        return m_held && (m_addr == a) && (m_size == s);
    endfunction

    function automatic bit exp_pass(input bit st, input bit clr, input bit hit,
                                    input bit sh, input bit gp);
        return st && hit && !clr && (!sh || gp);
    endfunction

    // One request cycle: drive at negedge, check the query before the edge,
    // check registered results just after the edge.
    task automatic cyc(input bit ld, input bit st, input bit clr,
                       input logic [AW-1:0] a, input logic [1:0] s,
                       input logic [DW-1:0] d, input bit sh, input bit gp);
        bit    hit, ep, eq;
        string tag;
        @(negedge clk);
        ld_req = ld; st_req = st; clr_req = clr;
        ld_addr = a; ld_size = s; st_addr = a; st_size = s; st_data = d;
        shareable = sh; sys_pass = gp;
        hit = exp_hit(a, s);
        ep  = exp_pass(st, clr, hit, sh, gp);
        eq  = st && sh && hit && !clr;
        if (st && clr)      tag = "R9";
        else if (!m_held)   tag = "R4";
        else if (!hit)      tag = "R6";
        else if (sh)        tag = "R7";
        else                tag = "R3";
        #1;
        check("R8", "sys_query", DW'(sys_query), DW'(eq));
        if (clr || st) m_held = 0;
        else if (ld) begin m_held = 1; m_addr = a; m_size = s; end
        @(posedge clk); #1;
        ld_req = 0; st_req = 0; clr_req = 0;
        check("R10", "st_done", DW'(st_done), DW'(st));
        if (st) begin
            check(tag, "st_status", DW'(st_status), DW'(!ep));
            check(tag, "wr_en", DW'(wr_en), DW'(ep));
            if (ep) begin
                check("R3", "wr_addr", DW'(wr_addr), DW'(a));
                check("R3", "wr_size", DW'(wr_size), DW'(s));
                check("R3", "wr_data", wr_data, d);
            end
        end else begin
            check("R10", "wr_en idle", DW'(wr_en), '0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ld, st, clr, sh, gp;
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        rst_n = 0; ld_req = 0; st_req = 0; clr_req = 0;
        ld_addr = '0; st_addr = '0; ld_size = '0; st_size = '0; st_data = '0;
        shareable = 0; sys_pass = 0;
        repeat (4) @(posedge clk);
        #1;
        check("R1", "wr_en reset", DW'(wr_en), '0);
        check("R1", "st_done reset", DW'(st_done), '0);
        check("R1", "st_status reset", DW'(st_status), '0);
        check("R1", "sys_query reset", DW'(sys_query), '0);
        @(negedge clk); rst_n = 1;

        // R1: first store after reset fails
        cyc(0, 1, 0, 32'h100, 2, 64'h11, 0, 1);
        // R3 + R5: success then second store fails
        cyc(1, 0, 0, 32'h100, 2, 0, 0, 0);
        cyc(0, 1, 0, 32'h100, 2, 64'hDEAD_BEEF_0123_4567, 0, 0);
        cyc(0, 1, 0, 32'h100, 2, 64'h22, 0, 0);
        // R2: re-marking replaces the reservation
        cyc(1, 0, 0, 32'h200, 3, 0, 0, 0);
        cyc(1, 0, 0, 32'h300, 1, 0, 0, 0);
        cyc(0, 1, 0, 32'h300, 1, 64'h33, 0, 0);
        // R6: address mismatch fails and clears
        cyc(1, 0, 0, 32'h400, 2, 0, 0, 0);
        cyc(0, 1, 0, 32'h404, 2, 64'h44, 0, 0);
        cyc(0, 1, 0, 32'h400, 2, 64'h45, 0, 0);
        // R6: size mismatch
        cyc(1, 0, 0, 32'h500, 0, 0, 0, 0);
        cyc(0, 1, 0, 32'h500, 1, 64'h55, 0, 0);
        // R7: shareable, system verdict fail then pass
        cyc(1, 0, 0, 32'h600, 3, 0, 1, 0);
        cyc(0, 1, 0, 32'h600, 3, 64'h66, 1, 0);
        cyc(1, 0, 0, 32'h600, 3, 0, 1, 0);
        cyc(0, 1, 0, 32'h600, 3, 64'h67, 1, 1);
        // R8: shareable store without local reservation, no query
        cyc(0, 1, 0, 32'h600, 3, 64'h68, 1, 1);
        // R9: clear drops reservation; clear beats store; load loses to clear/store
        cyc(1, 0, 0, 32'h700, 2, 0, 0, 0);
        cyc(0, 0, 1, 32'h700, 2, 0, 0, 0);
        cyc(0, 1, 0, 32'h700, 2, 64'h77, 0, 0);
        cyc(1, 0, 0, 32'h700, 2, 0, 1, 1);
        cyc(0, 1, 1, 32'h700, 2, 64'h78, 1, 1);
        cyc(1, 0, 1, 32'h700, 2, 0, 0, 0);
        cyc(0, 1, 0, 32'h700, 2, 64'h79, 0, 0);
        cyc(1, 0, 0, 32'h800, 2, 0, 0, 0);
        cyc(1, 1, 0, 32'h800, 2, 64'h80, 0, 0);
        cyc(0, 1, 0, 32'h800, 2, 64'h81, 0, 0);

        // Seeded random mix over a small address pool
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            logic [AW-1:0] a;
            logic [1:0] s;
            op  = $urandom_range(0, 9);
            ld  = (op <= 3);
            st  = (op >= 4 && op <= 7);
            clr = (op == 8);
            a   = 32'h1000 + 32'($urandom_range(0, 2)) * 8;
            s   = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
            sh  = 1'($urandom_range(0, 1));
            gp  = ($urandom_range(0, 3) != 0);
            cyc(ld, st, clr, a, s, {$urandom, $urandom}, sh, gp);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule